// File: doc/BRIEF.md
# Sliding-Window Correlator with Peak Index

This block finds where a short stored pattern best lines up inside a longer waveform. A 16-sample reference pattern is written beforehand through a small write port. A start pulse, sampled together with a base address, launches a run. The block then reads the 128 one-byte samples of the search waveform from a byte-wide single-port memory, one read per cycle. Each sample moves into a 16-entry shift register. For every alignment the 16 products between the window and the reference are formed in the same cycle and added up. The block keeps track of which alignment gives the largest sum.

Sample positions past the end of the waveform count as zero, so the last fifteen alignments cover only part of the pattern. After the last of the 128 alignments has been scored, the block raises a one-cycle done pulse together with the 7-bit index of the best alignment. The individual correlation values are not made visible.

Top module: `xcorr_peak`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it, busy_o, done_o and mem_re_o are 0 and peak_idx_o is 0.
- R2: A start accepted at a clock edge makes mem_re_o high in the 128 cycles that follow. In each of those cycles mem_addr_o is base_addr_i (as sampled at the start edge) plus 0, 1, ..., 127, wrapping modulo 2^AW. mem_re_o is low at all other times. Read data is taken one cycle after its read cycle.
- R3: The reported index is the shift s in 0..127 that maximises the sum over k = 0..15 of ref[k]*x[s+k]. Both operands are unsigned 8-bit values, and x[p] = 0 for p > 127.
- R4: When several shifts share the largest sum, the lowest shift index is reported.
- R5: done_o is high for exactly one cycle, after the 145th clock edge that follows the start edge. peak_idx_o carries the result in that cycle and holds it until the next done pulse.
- R6: busy_o is high from the start edge until the edge that raises done_o, and it is low while done_o is high.
- R7: A start_i pulse while busy_o is high is ignored. The addresses, the timing and the result of the current run do not change.
- R8: Writing the reference with ref_we_i at an edge while busy_o is low sets ref[ref_addr_i] = ref_data_i. Tap k multiplies x[s+k], so tap 0 meets the earliest sample of the window. Writes made while busy_o is high are ignored.
- R9: Sums up to 16*255*255 are scored without loss, so runs where every window is saturated still produce the correct index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted when not busy |
| base_addr_i | input | AW | Address of the waveform's first sample |
| ref_we_i | input | 1 | Reference tap write enable |
| ref_addr_i | input | 4 | Reference tap index |
| ref_data_i | input | 8 | Reference tap value |
| mem_re_o | output | 1 | Search memory read strobe |
| mem_addr_o | output | AW | Search memory read address |
| mem_data_i | input | 8 | Search memory read data, one cycle after the read |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle result strobe |
| peak_idx_o | output | 7 | Shift index of the largest correlation |

## Verification
The bench goes after the tail alignments. A design that did not feed zeros past sample 127, or that stopped after shift 112, would miss a peak planted at the very last sample, or would report the wrong member of a group of tied partial windows. Tie tests with all-zero and all-saturated data catch a comparison that uses greater-or-equal, because such a design reports the highest tied shift instead of the lowest. Single-impulse patterns on the last tap catch a reversed tap order, which moves the peak by 15 positions. Fully saturated windows catch a truncated accumulator, because the wrapped sums choose a different index. Start pulses and reference writes made in the middle of a run catch a design that restarts or that lets a write corrupt the current result.

// File: rtl/corr_pkg.sv
package corr_pkg;
  parameter int SW    = 8;
  parameter int NTAP  = 16;
  parameter int NSAMP = 128;

  localparam int PW   = 2 * SW;
  localparam int ACCW = PW + $clog2(NTAP);
  localparam int IW   = $clog2(NSAMP);
  localparam int TW   = $clog2(NTAP);
  localparam int NIN  = NSAMP + NTAP - 1;
  localparam int CW   = $clog2(NIN + 1);

  typedef logic [SW-1:0]   samp_t;
  typedef logic [ACCW-1:0] acc_t;
  typedef logic [IW-1:0]   idx_t;
  typedef logic [CW-1:0]   cnt_t;
endpackage

// File: rtl/corr_fetch.sv
module corr_fetch
  import corr_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic          fin_i,
  output logic          go_o,
  output logic          busy_o,
  output logic          mem_re_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          sh_o,
  output logic          zero_o
);
  logic          busy_q, run_q, sh_q, zero_q;
  cnt_t          cnt_q;
  logic [AW-1:0] base_q;

  assign go_o = start_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
      sh_q   <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      if (go_o) busy_q <= 1'b1;
      else if (fin_i) busy_q <= 1'b0;
      if (go_o) begin
        run_q  <= 1'b1;
        cnt_q  <= '0;
        base_q <= base_addr_i;
      end else if (run_q) begin
        if (cnt_q == cnt_t'(NIN - 1)) run_q <= 1'b0;
        else cnt_q <= cnt_q + 1'b1;
      end
      // data of a read arrives one cycle later; past the end, shift zeros
      sh_q   <= run_q;
      zero_q <= cnt_q >= cnt_t'(NSAMP);
    end
  end

  assign busy_o     = busy_q;
  assign mem_re_o   = run_q && (cnt_q < cnt_t'(NSAMP));
  assign mem_addr_o = base_q + AW'(cnt_q);
  assign sh_o       = sh_q;
  assign zero_o     = zero_q;

  AST_RD_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> busy_o); // R2
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && $past(mem_re_o)) |-> (mem_addr_o == $past(mem_addr_o) + 1'b1)); // R2
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o && !fin_i) |=> (busy_o && $stable(base_q))); // R7
endmodule

// File: rtl/corr_window.sv
module corr_window
  import corr_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    go_i,
  input  logic                    busy_i,
  input  logic                    sh_i,
  input  logic                    zero_i,
  input  samp_t                   din_i,
  input  logic                    ref_we_i,
  input  logic [TW-1:0]           ref_addr_i,
  input  samp_t                   ref_data_i,
  output logic [NTAP-1:0][SW-1:0] win_o,
  output logic [NTAP-1:0][SW-1:0] ref_o,
  output logic                    vld_o,
  output idx_t                    idx_o
);
  logic [NTAP-1:0][SW-1:0] win_q, ref_q;
  cnt_t                    in_cnt_q;
  logic                    vld_q;
  idx_t                    idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= '0;
    end else if (ref_we_i && !busy_i) begin
      ref_q[ref_addr_i] <= ref_data_i;
    end
  end

  // tap NTAP-1 takes the newest sample; tap 0 holds the oldest
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
    end else if (sh_i) begin
      for (int k = 0; k < NTAP - 1; k++) win_q[k] <= win_q[k+1];
      win_q[NTAP-1] <= zero_i ? '0 : din_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cnt_q <= '0;
      vld_q    <= 1'b0;
      idx_q    <= '0;
    end else begin
      if (go_i) in_cnt_q <= '0;
      else if (sh_i) in_cnt_q <= in_cnt_q + 1'b1;
      vld_q <= sh_i && (in_cnt_q >= cnt_t'(NTAP - 1));
      idx_q <= idx_t'(in_cnt_q - cnt_t'(NTAP - 1));
    end
  end

  assign win_o = win_q;
  assign ref_o = ref_q;
  assign vld_o = vld_q;
  assign idx_o = idx_q;

  AST_REF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(ref_q)); // R8
  AST_WIN_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_i |=> (win_q[NTAP-2] == $past(win_q[NTAP-1]))); // R8
endmodule

// File: rtl/corr_dot.sv
module corr_dot
  import corr_pkg::*;
(
  input  logic [NTAP-1:0][SW-1:0] win_i,
  input  logic [NTAP-1:0][SW-1:0] ref_i,
  output acc_t                    dot_o
);
  logic [NTAP-1:0][PW-1:0] prod;

  for (genvar g = 0; g < NTAP; g++) begin : g_mul
    assign prod[g] = PW'(win_i[g]) * PW'(ref_i[g]);
  end

  always_comb begin
    dot_o = '0;
    for (int i = 0; i < NTAP; i++) dot_o = dot_o + ACCW'(prod[i]);
  end
endmodule

// File: rtl/corr_peak.sv
module corr_peak
  import corr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  idx_t idx_i,
  input  acc_t dot_i,
  output logic fin_o,
  output logic done_o,
  output idx_t peak_o
);
  acc_t best_q;
  idx_t bidx_q, peak_q;
  logic done_q, upd;

  // strict compare keeps the earliest of equal maxima
  assign upd   = vld_i && ((idx_i == '0) || (dot_i > best_q));
  assign fin_o = vld_i && (idx_i == idx_t'(NSAMP - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      best_q <= '0;
      bidx_q <= '0;
      peak_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (upd) begin
        best_q <= dot_i;
        bidx_q <= idx_i;
      end
      done_q <= fin_o;
      if (fin_o) peak_q <= upd ? idx_i : bidx_q;
    end
  end

  assign done_o = done_q;
  assign peak_o = peak_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_BEST_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && idx_i != '0) |=> (best_q >= $past(best_q))); // R3
  AST_TIE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && idx_i != '0 && dot_i == best_q) |=> (bidx_q == $past(bidx_q))); // R4
endmodule

// File: rtl/xcorr_peak.sv
module xcorr_peak
  import corr_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic          ref_we_i,
  input  logic [3:0]    ref_addr_i,
  input  logic [7:0]    ref_data_i,
  output logic          mem_re_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [6:0]    peak_idx_o
);
  logic go, fin, sh, zero, vld;
  idx_t idx;
  acc_t dot;
  logic [NTAP-1:0][SW-1:0] win, rf;

  corr_fetch #(.AW(AW)) u_fetch (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .base_addr_i(base_addr_i),
    .fin_i(fin), .go_o(go), .busy_o(busy_o), .mem_re_o(mem_re_o),
    .mem_addr_o(mem_addr_o), .sh_o(sh), .zero_o(zero)
  );

  corr_window u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go), .busy_i(busy_o), .sh_i(sh),
    .zero_i(zero), .din_i(mem_data_i), .ref_we_i(ref_we_i), .ref_addr_i(ref_addr_i),
    .ref_data_i(ref_data_i), .win_o(win), .ref_o(rf), .vld_o(vld), .idx_o(idx)
  );

  corr_dot u_dot (.win_i(win), .ref_i(rf), .dot_o(dot));

  corr_peak u_peak (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(vld), .idx_i(idx), .dot_i(dot),
    .fin_o(fin), .done_o(done_o), .peak_o(peak_idx_o)
  );

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R6
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o)); // R6
endmodule

// File: tb/xcorr_peak_test.sv
module xcorr_peak_test;
  localparam int AW = 10;
  localparam int MS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] base_addr_i = '0;
  logic          ref_we_i = 1'b0;
  logic [3:0]    ref_addr_i = '0;
  logic [7:0]    ref_data_i = '0;
  logic          mem_re_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0]    mem_data_i = '0;
  logic          busy_o, done_o;
  logic [6:0]    peak_idx_o;

  int checks = 0, failures = 0, cyc = 0;
  logic [7:0] mem [MS];
  logic [7:0] mref [16];
  int m_cnt = -1, m_base = 0, m_exp = 0;
  string m_tag = "R3";

  always #5 clk = ~clk;

  xcorr_peak #(.AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .base_addr_i(base_addr_i),
    .ref_we_i(ref_we_i), .ref_addr_i(ref_addr_i), .ref_data_i(ref_data_i),
    .mem_re_o(mem_re_o), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
    .busy_o(busy_o), .done_o(done_o), .peak_idx_o(peak_idx_o)
  );

  always @(posedge clk) if (mem_re_o) mem_data_i <= mem[mem_addr_o];

  function automatic int exp_peak(int base);
    longint best = -1;
    int bi = 0;
    for (int s = 0; s < 128; s++) begin
      longint sum = 0;
      for (int k = 0; k < 16; k++)
        if (s + k < 128) sum += longint'(mref[k]) * longint'(mem[(base + s + k) % MS]);
      if (sum > best) begin best = sum; bi = s; end
    end
    return bi;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // reference model: advances on every edge
  always @(posedge clk) begin
    if (rst_ni) begin
      bit mbusy;
      mbusy = (m_cnt >= 0 && m_cnt <= 144);
      if (ref_we_i && !mbusy) mref[ref_addr_i] = ref_data_i;
      if (start_i && !mbusy) begin
        m_cnt = 0;
        m_base = int'(base_addr_i);
        m_exp = exp_peak(m_base);
      end else if (m_cnt >= 0 && m_cnt < 146) m_cnt++;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni) begin
      bit ere, ebusy, edone;
      ere = (m_cnt >= 0 && m_cnt <= 127);
      ebusy = (m_cnt >= 0 && m_cnt <= 144);
      edone = (m_cnt == 145);
      chk(mem_re_o == ere, "R2 mem_re_o", mem_re_o, ere);
      if (ere) chk(int'(mem_addr_o) == (m_base + m_cnt) % MS, "R2 mem_addr_o",
                   mem_addr_o, (m_base + m_cnt) % MS);
      chk(busy_o == ebusy, "R6 busy_o", busy_o, ebusy);
      chk(done_o == edone, "R5 done_o", done_o, edone);
      if (edone) chk(int'(peak_idx_o) == m_exp, m_tag, peak_idx_o, m_exp);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr_ref(input int k, input int v);
    @(negedge clk);
    ref_we_i = 1'b1; ref_addr_i = 4'(k); ref_data_i = 8'(v);
    @(negedge clk);
    ref_we_i = 1'b0;
  endtask

  task automatic set_ref_all(input int v);
    for (int k = 0; k < 16; k++) wr_ref(k, v);
  endtask

  task automatic clr_mem();
    for (int i = 0; i < MS; i++) mem[i] = 8'h00;
  endtask

  task automatic rnd_mem();
    for (int i = 0; i < MS; i++) mem[i] = 8'($urandom);
  endtask

  // poke: 1 = extra start mid-run (R7), 2 = reference write mid-run (R8)
  task automatic run(input int base, input string tag, input int poke, input int hand);
    m_tag = tag;
    @(negedge clk);
    start_i = 1'b1; base_addr_i = AW'(base);
    @(negedge clk);
    start_i = 1'b0;
    if (hand >= 0) chk(m_exp == hand, {tag, " model"}, m_exp, hand);
    for (int i = 0; i < 152; i++) begin
      @(negedge clk);
      if (i == 40 && poke == 1) begin start_i = 1'b1; base_addr_i = AW'(base + 333); end
      if (i == 41) start_i = 1'b0;
      if (i == 60 && poke == 2) begin ref_we_i = 1'b1; ref_addr_i = 4'd3; ref_data_i = 8'hFF; end
      if (i == 61) ref_we_i = 1'b0;
    end
  endtask

  initial begin
    for (int k = 0; k < 16; k++) mref[k] = 8'h00;
    clr_mem();
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0 && mem_re_o == 1'b0, "R1 ctrl in reset",
        {busy_o, done_o, mem_re_o}, 0);
    chk(peak_idx_o == 7'd0, "R1 peak in reset", peak_idx_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0 && mem_re_o == 1'b0, "R1 ctrl after reset",
        {busy_o, done_o, mem_re_o}, 0);

    // random patterns
    for (int t = 0; t < 3; t++) begin
      rnd_mem();
      for (int k = 0; k < 16; k++) wr_ref(k, int'($urandom) & 255);
      run(t * 100, "R3 random", 0, -1);
    end

    // impulse on last tap: tap order
    clr_mem(); mem[200 + 50] = 8'd200;
    set_ref_all(0); wr_ref(15, 1);
    run(200, "R8 tap order", 0, 35);

    // peak at last sample, tap 0: final shift
    clr_mem(); mem[127] = 8'd9;
    set_ref_all(0); wr_ref(0, 1);
    run(0, "R3 last shift", 0, 127);

    // tied partial windows at the tail
    clr_mem(); mem[127] = 8'd255;
    set_ref_all(1);
    run(0, "R4 tail tie", 0, 112);

    // all zero: every shift ties
    clr_mem();
    run(0, "R4 all zero", 0, 0);

    // saturated sums
    for (int i = 0; i < MS; i++) mem[i] = (i < 16) ? 8'd250 : 8'd255;
    set_ref_all(255);
    run(0, "R9 saturated", 0, 16);

    // start ignored while busy
    rnd_mem();
    for (int k = 0; k < 16; k++) wr_ref(k, int'($urandom) & 255);
    run(64, "R7 start busy", 1, -1);

    // reference write ignored while busy
    wr_ref(3, 0);
    run(128, "R8 write busy", 2, -1);

    // address wrap across top of memory
    run(900, "R2 wrap", 0, -1);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule